// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Controller

This block holds the replacement history of an eight-way set-associative cache with 128 sets. For every set it keeps a seven-node binary decision tree. Node 0 is the root. Node 1 decides among ways 0 to 3, and node 2 decides among ways 4 to 7. Nodes 3, 4, 5 and 6 each decide within one pair of ways: 0/1, 2/3, 4/5 and 6/7. Whenever the cache hits or fills a way, the access port rewrites the three nodes on that way's path.

A normal access marks the way as most recently used, so the tree points away from it. A hint access writes the opposite values on the same path, so the touched way becomes the next victim.

The replacement port takes a set number and that set's per-way valid vector. It returns a victim way combinationally. By default an invalid way is preferred over the tree's choice. In flush-assist mode the valid vector is ignored and the tree alone decides. A flash-clear input returns every set to the all-zero tree in one cycle.

Top module: `plru_repl_ctrl`

## Requirements
- R1: After the active-low reset, every set's seven tree nodes are 0. A lookup with all ways valid then returns way 0 for any set.
- R2: A normal access to way w sets each node on w's path to the inverse of the address bit of w that this node decides on. Node 0 decides on bit 2, nodes 1 and 2 on bit 1, and nodes 3 to 6 on bit 0. The other four nodes keep their values.
- R3: A hint access (acc_hint=1) writes each node on w's path equal to w's corresponding address bit. The other four nodes keep their values. The next tree-mode lookup of that set returns w.
- R4: In tree mode the victim is found by a walk from the root. A node value of 0 goes to the lower-numbered half and 1 goes to the upper half. The child of node n taken on value b is node 2n+1+b. The three node values read on the walk, root first, form the victim way number, most significant bit first.
- R5: With flush_assist=0, if any bit of rpl_valid is 0 (bit i is 1 when way i is valid), the victim is the lowest-numbered way whose valid bit is 0.
- R6: With flush_assist=1 the valid vector has no effect, and the victim is the tree walk of R4.
- R7: clr_all=1 zeroes the trees of all sets at the next clock edge. It takes priority over an access in the same cycle.
- R8: A lookup of a set that is being updated in the same cycle returns the victim from the state before the update. The update is visible from the next cycle on.
- R9: An access changes only the tree of the set it addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_all | input | 1 | Flash-clear of all trees |
| acc_en | input | 1 | Access strobe |
| acc_set | input | 7 | Set of the access |
| acc_way | input | 3 | Way hit or filled |
| acc_hint | input | 1 | 1: hint (make victim), 0: normal use |
| rpl_set | input | 7 | Set for victim lookup |
| rpl_valid | input | 8 | Per-way valid bits of that set |
| flush_assist | input | 1 | 1: ignore valid bits |
| victim_way | output | 3 | Chosen victim way (combinational) |

## Verification
The hardest state to reach from the ports is a tree whose unused branches hold a mix of ones and zeros. Only then does a wrong node index or a wrong polarity show up, because a lookup reveals just the three nodes on one path. The stimulus first replays fixed orderings of normal and hint accesses. It then runs several thousand cycles of random accesses, each paired with a lookup. Accesses concentrate on a few sets, so the trees become deeply mixed and collide with same-cycle lookups. Lookups alternate between all-valid, partly invalid and flush-assist modes.

// File: rtl/plru_pkg.sv
// Package plru_pkg: shared types for the pseudo-LRU replacement controller.
// Assumes nothing beyond IEEE 1800-2017.
package plru_pkg;
    // Kind of tree update applied by an access
    typedef enum logic {
        UPD_MRU  = 1'b0,
        UPD_HINT = 1'b1
    } upd_kind_e;
endpackage

// File: rtl/plru_path_update.sv
// Module plru_path_update: computes the next tree for one set from its
// current tree, the accessed way and the update kind. Only the nodes on the
// root-to-leaf path of the way are rewritten; the rest are passed through.
// Assumes WAYS is a power of two and nodes are stored in heap order
// (children of node n are 2n+1 and 2n+2).
module plru_path_update
    import plru_pkg::*;
#(
    parameter int WAYS = 8
) (
    input  logic [WAYS-2:0]         cur_tree,
    input  logic [$clog2(WAYS)-1:0] way,
    input  upd_kind_e               kind,
    output logic [WAYS-2:0]         nxt_tree
);
    localparam int WAY_W = $clog2(WAYS);

    // Rewrite each node on the path: hint copies the way bit, MRU inverts it
    always_comb begin
        nxt_tree = cur_tree;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            int node;
            node = (1 << lvl) - 1 + int'(way >> (WAY_W - lvl));
            nxt_tree[node] = way[WAY_W-1-lvl] ^ (kind == UPD_MRU);
        end
    end
endmodule

// File: rtl/plru_victim_sel.sv
// Module plru_victim_sel: picks a victim way for one set. It walks the tree
// from the root, or, when flush assist is off and some way is invalid, it
// takes the lowest-numbered invalid way. Purely combinational.
// Assumes WAYS is a power of two and the tree is in heap order.
module plru_victim_sel #(
    parameter int WAYS = 8
) (
    input  logic [WAYS-2:0]         tree,
    input  logic [WAYS-1:0]         valid,
    input  logic                    flush_assist,
    output logic [$clog2(WAYS)-1:0] victim
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] walk_way;
    logic [WAY_W-1:0] first_inv;
    logic             any_inv;

    // Follow the node values from root to leaf; the values read form the way
    always_comb begin
        int node;
        node = 0;
        walk_way = '0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            walk_way[WAY_W-1-lvl] = tree[node];
            node = 2 * node + 1 + int'(tree[node]);
        end
    end

    // Priority search for the lowest-numbered invalid way
    always_comb begin
        first_inv = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) first_inv = WAY_W'(i);
        end
    end

    assign any_inv = ~&valid;

    // Choose between the invalid-way preference and the tree walk
    always_comb begin
        victim = (any_inv && !flush_assist) ? first_inv : walk_way;
    end
endmodule

// File: rtl/plru_state_ram.sv
// Module plru_state_ram: per-set storage of the replacement trees, built as
// one flop register per set. One write port, two asynchronous read ports.
// Reset and flash-clear zero every set; clear wins over a write.
module plru_state_ram #(
    parameter int SETS   = 128,
    parameter int TREE_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    we,
    input  logic [$clog2(SETS)-1:0] waddr,
    input  logic [TREE_W-1:0]       wdata,
    input  logic [$clog2(SETS)-1:0] raddr_a,
    output logic [TREE_W-1:0]       rdata_a,
    input  logic [$clog2(SETS)-1:0] raddr_b,
    output logic [TREE_W-1:0]       rdata_b
);
    logic [TREE_W-1:0] mem [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        // Hold one set's tree: zero on reset or clear, load on matching write
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                mem[s] <= '0;
            end else if (we && (int'(waddr) == s)) begin
                mem[s] <= wdata;
            end
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/plru_repl_ctrl.sv
// Module plru_repl_ctrl: tree pseudo-LRU replacement controller for a
// set-associative cache. The access port performs a read-modify-write of one
// set's tree (normal or hint update). The replacement port returns a victim
// combinationally from the stored (pre-update) tree.
// Assumes WAYS is a power of two, at most one access per cycle, and
// synchronous active-low reset.
module plru_repl_ctrl
    import plru_pkg::*;
#(
    parameter int SETS = 128,
    parameter int WAYS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_all,
    input  logic                    acc_en,
    input  logic [$clog2(SETS)-1:0] acc_set,
    input  logic [$clog2(WAYS)-1:0] acc_way,
    input  logic                    acc_hint,
    input  logic [$clog2(SETS)-1:0] rpl_set,
    input  logic [WAYS-1:0]         rpl_valid,
    input  logic                    flush_assist,
    output logic [$clog2(WAYS)-1:0] victim_way
);
    localparam int TREE_W = WAYS - 1;

    logic [TREE_W-1:0] acc_tree_cur;
    logic [TREE_W-1:0] acc_tree_nxt;
    logic [TREE_W-1:0] rpl_tree;
    upd_kind_e         acc_kind;

    assign acc_kind = acc_hint ? UPD_HINT : UPD_MRU;

    plru_state_ram #(
        .SETS   (SETS),
        .TREE_W (TREE_W)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_all),
        .we      (acc_en),
        .waddr   (acc_set),
        .wdata   (acc_tree_nxt),
        .raddr_a (acc_set),
        .rdata_a (acc_tree_cur),
        .raddr_b (rpl_set),
        .rdata_b (rpl_tree)
    );

    plru_path_update #(
        .WAYS (WAYS)
    ) u_upd (
        .cur_tree (acc_tree_cur),
        .way      (acc_way),
        .kind     (acc_kind),
        .nxt_tree (acc_tree_nxt)
    );

    plru_victim_sel #(
        .WAYS (WAYS)
    ) u_vic (
        .tree         (rpl_tree),
        .valid        (rpl_valid),
        .flush_assist (flush_assist),
        .victim       (victim_way)
    );
endmodule

// File: rtl/plru_repl_ctrl_chk.sv
// Module plru_repl_ctrl_chk: port-level properties of plru_repl_ctrl,
// attached to every instance by the bind statement at the end of this file.
module plru_repl_ctrl_chk #(
    parameter int SETS = 128,
    parameter int WAYS = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clr_all,
    input logic                    acc_en,
    input logic [$clog2(SETS)-1:0] acc_set,
    input logic [$clog2(WAYS)-1:0] acc_way,
    input logic                    acc_hint,
    input logic [$clog2(SETS)-1:0] rpl_set,
    input logic [WAYS-1:0]         rpl_valid,
    input logic                    flush_assist,
    input logic [$clog2(WAYS)-1:0] victim_way
);
    logic tree_mode;
    assign tree_mode = (&rpl_valid) || flush_assist;

    // R5: the chosen way is itself invalid
    p_pick_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_assist && !(&rpl_valid)) |-> !rpl_valid[victim_way]);

    // R5: every way below the chosen one is valid
    p_lowest_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_assist && !(&rpl_valid)) |->
        ((rpl_valid | ~((WAYS'(1) << victim_way) - WAYS'(1))) == '1));

    // R7: after a flash-clear the tree walk lands on way 0
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (!tree_mode || victim_way == '0));

    // R3: a hint access makes the touched way the next tree-mode victim
    p_hint_victim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_hint && !clr_all) |=>
        (rpl_set != $past(acc_set) || !tree_mode || victim_way == $past(acc_way)));

    // R2: a normal access steers the next tree-mode victim away from that way
    p_mru_avoid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_hint && !clr_all) |=>
        (rpl_set != $past(acc_set) || !tree_mode || victim_way != $past(acc_way)));
endmodule

bind plru_repl_ctrl plru_repl_ctrl_chk #(
    .SETS (SETS),
    .WAYS (WAYS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_all      (clr_all),
    .acc_en       (acc_en),
    .acc_set      (acc_set),
    .acc_way      (acc_way),
    .acc_hint     (acc_hint),
    .rpl_set      (rpl_set),
    .rpl_valid    (rpl_valid),
    .flush_assist (flush_assist),
    .victim_way   (victim_way)
);

// File: tb/sim_plru_repl_ctrl.sv
// Bench sim_plru_repl_ctrl: scoreboard bench. The driver task keeps a model
// of every set's tree, pushes the expected victim of each lookup into a
// queue, and the monitor pops and compares at the falling edge.
module sim_plru_repl_ctrl;
    localparam int SETS = 128;
    localparam int WAYS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_all = 1'b0;
    logic       acc_en = 1'b0;
    logic [6:0] acc_set = '0;
    logic [2:0] acc_way = '0;
    logic       acc_hint = 1'b0;
    logic [6:0] rpl_set = '0;
    logic [7:0] rpl_valid = '1;
    logic       flush_assist = 1'b0;
    logic [2:0] victim_way;

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    logic [6:0] model [SETS];
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    plru_repl_ctrl #(.SETS(SETS), .WAYS(WAYS)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .acc_en(acc_en),
        .acc_set(acc_set), .acc_way(acc_way), .acc_hint(acc_hint),
        .rpl_set(rpl_set), .rpl_valid(rpl_valid),
        .flush_assist(flush_assist), .victim_way(victim_way)
    );

    // Expected victim from the requirements (R4, R5, R6)
    function automatic logic [2:0] m_victim(logic [6:0] t, logic [7:0] v, bit fa);
        if (!fa && v != 8'hFF) begin
            for (int i = 0; i < 8; i++) if (!v[i]) return 3'(i);
        end
        if (!t[0]) return t[1] ? {2'b01, t[4]} : {2'b00, t[3]};
        return t[2] ? {2'b11, t[6]} : {2'b10, t[5]};
    endfunction

    // Expected tree after an access (R2, R3)
    function automatic logic [6:0] m_update(logic [6:0] t, logic [2:0] w, bit hint);
        logic [6:0] r;
        logic       inv;
        r = t;
        inv = !hint;
        r[0] = w[2] ^ inv;
        if (!w[2]) begin
            r[1] = w[1] ^ inv;
            if (!w[1]) r[3] = w[0] ^ inv; else r[4] = w[0] ^ inv;
        end else begin
            r[2] = w[1] ^ inv;
            if (!w[1]) r[5] = w[0] ^ inv; else r[6] = w[0] ^ inv;
        end
        return r;
    endfunction

    // Driver: one cycle of stimulus, expected lookup result pushed first
    task automatic step(bit clr, bit aen, int aset, int away, bit hint,
                        bit look, int rset, logic [7:0] v, bit fa, string tag);
        item_t it;
        @(posedge clk);
        #1;
        clr_all = clr;
        acc_en = aen;
        acc_set = 7'(aset);
        acc_way = 3'(away);
        acc_hint = hint;
        rpl_set = 7'(rset);
        rpl_valid = v;
        flush_assist = fa;
        if (look) begin
            it.exp = m_victim(model[rset], v, fa);
            it.tag = tag;
            sb_q.push_back(it);
        end
        if (clr) begin
            for (int s = 0; s < SETS; s++) model[s] = '0;
        end else if (aen) begin
            model[aset] = m_update(model[aset], 3'(away), hint);
        end
    endtask

    task automatic look(int rset, logic [7:0] v, bit fa, string tag);
        step(0, 0, 0, 0, 0, 1, rset, v, fa, tag);
    endtask

    task automatic touch(int aset, int away, bit hint);
        step(0, 1, aset, away, hint, 0, 0, 8'hFF, 0, "");
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        acc_en = 1'b0;
        clr_all = 1'b0;
        for (int s = 0; s < SETS; s++) model[s] = '0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // Monitor: compare the design's victim with the queued expectation
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (victim_way !== it.exp) begin
                n_errors++;
                $display("FAIL %s: victim_way=%0d expected %0d", it.tag, victim_way, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < SETS; s++) model[s] = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: reset state, all trees zero
        look(0, 8'hFF, 0, "R1");
        look(127, 8'hFF, 0, "R1");
        look(64, 8'hFF, 1, "R1");

        // R2: normal use of way 0 moves the victim to way 4
        touch(5, 0, 0);
        look(5, 8'hFF, 0, "R2");
        touch(5, 4, 0);
        look(5, 8'hFF, 0, "R2");
        // R3: hint on way 5 makes it the victim; other branch bits kept
        touch(5, 5, 1);
        look(5, 8'hFF, 0, "R3");
        touch(5, 2, 1);
        look(5, 8'hFF, 0, "R3");
        // R9: neighbouring sets untouched
        look(4, 8'hFF, 0, "R9");
        look(6, 8'hFF, 0, "R9");

        // R4: fill all eight ways in order, then walk the victim sequence
        for (int w = 0; w < 8; w++) touch(9, w, 0);
        for (int k = 0; k < 8; k++) begin
            step(0, 1, 9, int'(m_victim(model[9], 8'hFF, 0)), 0, 1, 9, 8'hFF, 0, "R4");
        end

        // R5: invalid-way preference
        look(9, 8'b1101_1111, 0, "R5");
        look(9, 8'b0111_1111, 0, "R5");
        look(9, 8'b0000_0000, 0, "R5");
        look(9, 8'b1111_0110, 0, "R5");
        // R6: flush assist ignores valid bits
        look(9, 8'b1101_1111, 1, "R6");
        look(9, 8'b0000_0000, 1, "R6");

        // R8: update and lookup of the same set in one cycle
        step(0, 1, 9, 3, 1, 1, 9, 8'hFF, 0, "R8");
        look(9, 8'hFF, 0, "R8");

        // R7: flash clear wins over a same-cycle access
        touch(20, 1, 0);
        step(1, 1, 20, 6, 0, 1, 20, 8'hFF, 0, "R7");
        look(20, 8'hFF, 0, "R7");
        look(9, 8'hFF, 1, "R7");

        // R1: reset from a non-zero state
        touch(30, 0, 0);
        do_reset();
        look(30, 8'hFF, 0, "R1");

        // Random mix (R2, R3, R4, R5, R6, R8, R9)
        for (int n = 0; n < 4000; n++) begin
            int         aset;
            int         rset;
            logic [7:0] v;
            bit         fa;
            int         mode;
            aset = int'($urandom_range(0, 3)) * 37;
            rset = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 127)) : aset;
            mode = int'($urandom_range(0, 3));
            fa = (mode == 2);
            v = (mode == 1) ? 8'($urandom_range(0, 255)) : 8'hFF;
            step(($urandom_range(0, 499) == 0), ($urandom_range(0, 4) != 0), aset,
                 int'($urandom_range(0, 7)), ($urandom_range(0, 2) == 0),
                 1, rset, v, fa, "R4_R5_R6_R8_R9");
        end

        @(posedge clk);
        #1;
        acc_en = 1'b0;
        clr_all = 1'b0;
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule